// File: doc/BRIEF.md
# Framed Serial Slave with Frame-Sync Pulse

This block is the slave side of a framed serial link. The far end supplies a free-running serial clock. Words move between a small parallel register interface and the serial data pins. Each word boundary is marked by a frame-sync pulse one serial-clock period long on the select pin, which replaces the usual level chip-select.

A direction input chooses who owns the sync pulse. In the generating sub-mode the block drives the pulse itself as soon as software has loaded a transmit word. In the following sub-mode it watches the select pin and starts a word after it sees a pulse from the far end. All pin inputs pass through synchronizers into the system clock. Edges of the serial clock are found there, so the system clock must run at least four times faster than the serial clock.

Top module: `spi_frm_slave`

## Requirements
- R1: Framed operation runs only while master_en_i is 0 and frame_en_i is 1. In any other setting sdo_o and ss_o stay 0, ss_oe_o is 0, no word starts, and rx_full_o and underrun_o do not get set.
- R2: ss_oe_o is 1 exactly when framed operation is active and sync_dir_i is 0 (generating). With sync_dir_i at 1 the select pin is an input, and in generating mode ss_i has no effect.
- R3: In generating mode, once a transmit word is pending and no word is in progress, the next falling SCK edge drives ss_o to 1.
- R4: A generated sync pulse is high for exactly one SCK period and ends on the next falling edge.
- R5: The falling edge that ends the pulse drives bit 15 of the word on sdo_o. Each of the next 15 falling edges drives the next lower bit, so the word goes out MSB first.
- R6: In following mode, ss_i is sampled on rising SCK edges. A high sample starts a word, and its MSB is driven on the following falling edge.
- R7: During a word, sdi_i is sampled on each rising edge. After the 16th sample the assembled word (first bit in bit 15) appears on rd_data_o and rx_full_o goes to 1.
- R8: rd_en_i clears rx_full_o in the next cycle. If a word completes in the same cycle, the set wins.
- R9: If a word starts in following mode with no transmit word pending, the block sends zeros and sets underrun_o. The flag stays set until the next write on wr_en_i.
- R10: In following mode, a sync sampled in the middle of a word restarts the word on the next falling edge, and the partial receive word is discarded.
- R11: Words can run back to back. In following mode a sync sampled on the 16th rising edge starts the next word at once. In generating mode a word queued during a transfer gets its pulse on the falling edge right after the 16th rising edge.
- R12: sdo_o is 0 on every falling edge that is not inside a word, including the sync-pulse period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| master_en_i | input | 1 | Master enable; must be 0 for framed slave operation |
| frame_en_i | input | 1 | Frame enable; must be 1 for framed operation |
| sync_dir_i | input | 1 | 0: block drives sync pulse, 1: block samples sync pulse |
| wr_en_i | input | 1 | Load transmit word |
| wr_data_i | input | 16 | Transmit word |
| rd_en_i | input | 1 | Acknowledge receive word, clears rx_full_o |
| rd_data_o | output | 16 | Last received word |
| rx_full_o | output | 1 | Receive word waiting |
| underrun_o | output | 1 | Sticky: a word started without transmit data |
| sck_i | input | 1 | Serial clock from the far end |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out |
| ss_i | input | 1 | Select pin, input side |
| ss_o | output | 1 | Select pin, output side (sync pulse) |
| ss_oe_o | output | 1 | Select pin output enable |

## Verification
The in-RTL assertions check cycle-level invariants on every clock. A rising ss_o always follows a detected falling edge with a word pending and with the pin owned. A falling generated pulse always lands in the data state. The bit counter stays below the word length inside a word. rx_full_o rises only on word completion and falls only on a read. underrun_o rises only when no word was pending. The outputs stay quiet when framed operation is off. What only the bench scenarios can show is the end-to-end sequence: where the MSB lands relative to the pulse, the exact bit order, received data values, back-to-back framing, restarts on a mid-word sync, and underrun stickiness. These are checked against a behavioural model across both sub-modes and the inactive settings.

// File: rtl/spi_frm_pkg.sv
package spi_frm_pkg;
  parameter int unsigned SPI_WORD_W      = 16;
  parameter int unsigned SPI_SYNC_STAGES = 2;

  typedef enum logic [1:0] {
    FS_IDLE  = 2'd0,
    FS_PULSE = 2'd1,
    FS_DATA  = 2'd2
  } frm_state_e;
endpackage

// File: rtl/spi_frm_sync.sv
module spi_frm_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q <= '0;
    else         stg_q <= {stg_q[STAGES-2:0], d_i};
  end

  assign q_o = stg_q[STAGES-1];

  initial begin
    a_sync_depth: assert (STAGES >= 2) else $error("sync needs two stages");
  end
endmodule

// File: rtl/spi_frm_engine.sv
module spi_frm_engine
  import spi_frm_pkg::*;
#(
  parameter int unsigned WORD_W = SPI_WORD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              active_i,
  input  logic              sync_dir_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              ss_s_i,
  input  logic              sdi_s_i,
  input  logic              tx_valid_i,
  input  logic [WORD_W-1:0] tx_word_i,
  output logic              take_o,
  output logic              under_o,
  output logic              rx_done_o,
  output logic [WORD_W-1:0] rx_word_o,
  output logic              sdo_o,
  output logic              ss_o
);
  localparam int unsigned CNT_W = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  frm_state_e        st_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [WORD_W-1:0] tx_sh_q, rx_sh_q, rx_load;
  logic              pend_q, sdo_q, ss_q;
  logic              start_rx, start_pulse, start_gen;

  assign start_rx    = sync_dir_i && pend_q && fall_i;
  assign start_pulse = !sync_dir_i && fall_i && (st_q == FS_IDLE) && tx_valid_i;
  assign start_gen   = !sync_dir_i && fall_i && (st_q == FS_PULSE);
  assign rx_load     = tx_valid_i ? tx_word_i : '0;

  assign take_o    = active_i && ((start_rx && tx_valid_i) || start_pulse);
  assign under_o   = active_i && start_rx && !tx_valid_i;
  assign rx_done_o = active_i && rise_i && (st_q == FS_DATA) && (cnt_q == LAST);
  assign rx_word_o = {rx_sh_q[WORD_W-2:0], sdi_s_i};
  assign sdo_o     = sdo_q;
  assign ss_o      = ss_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= FS_IDLE;
      cnt_q   <= '0;
      tx_sh_q <= '0;
      rx_sh_q <= '0;
      pend_q  <= 1'b0;
      sdo_q   <= 1'b0;
      ss_q    <= 1'b0;
    end else if (!active_i) begin
      st_q   <= FS_IDLE;
      cnt_q  <= '0;
      pend_q <= 1'b0;
      sdo_q  <= 1'b0;
      ss_q   <= 1'b0;
    end else begin
      if (rise_i) begin
        if (sync_dir_i && ss_s_i) pend_q <= 1'b1;
        if (st_q == FS_DATA) begin
          rx_sh_q <= rx_word_o;
          cnt_q   <= cnt_q + 1'b1;
          if (cnt_q == LAST) st_q <= FS_IDLE;
        end
      end
      if (fall_i) begin
        if (start_rx) begin
          pend_q  <= 1'b0;
          st_q    <= FS_DATA;
          cnt_q   <= '0;
          sdo_q   <= rx_load[WORD_W-1];
          tx_sh_q <= rx_load << 1;
        end else if (start_gen) begin
          ss_q    <= 1'b0;
          st_q    <= FS_DATA;
          cnt_q   <= '0;
          sdo_q   <= tx_sh_q[WORD_W-1];
          tx_sh_q <= tx_sh_q << 1;
        end else if (start_pulse) begin
          ss_q    <= 1'b1;
          st_q    <= FS_PULSE;
          tx_sh_q <= tx_word_i;
          sdo_q   <= 1'b0;
        end else if (st_q == FS_DATA) begin
          sdo_q   <= tx_sh_q[WORD_W-1];
          tx_sh_q <= tx_sh_q << 1;
        end else begin
          sdo_q   <= 1'b0;
        end
      end
      if (sync_dir_i) ss_q <= 1'b0;
    end
  end

  // R3: pulse only rises off a detected transmit edge with a word pending
  a_r3_pulse_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ss_q) |-> $past(fall_i && tx_valid_i));

  // R4: pulse ends by entering the data phase
  a_r4_pulse_into_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ss_q) && active_i && !sync_dir_i |-> st_q == FS_DATA);

  // R7: bit counter inside a word never reaches the word length
  a_r7_cnt_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == FS_DATA |-> cnt_q < CNT_W'(WORD_W));

  // R1: nothing driven while framed operation is off
  a_r1_quiet_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |=> !ss_q && !sdo_q);
endmodule

// File: rtl/spi_frm_regs.sv
module spi_frm_regs
  import spi_frm_pkg::*;
#(
  parameter int unsigned WORD_W = SPI_WORD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  input  logic              take_i,
  input  logic              under_i,
  input  logic              rx_done_i,
  input  logic [WORD_W-1:0] rx_word_i,
  output logic              tx_valid_o,
  output logic [WORD_W-1:0] tx_word_o,
  output logic [WORD_W-1:0] rd_data_o,
  output logic              rx_full_o,
  output logic              underrun_o
);
  logic              tx_valid_q, rx_full_q, under_q;
  logic [WORD_W-1:0] tx_q, rx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_valid_q <= 1'b0;
      tx_q       <= '0;
      rx_q       <= '0;
      rx_full_q  <= 1'b0;
      under_q    <= 1'b0;
    end else begin
      if (wr_en_i) begin
        tx_q       <= wr_data_i;
        tx_valid_q <= 1'b1;
      end else if (take_i) begin
        tx_valid_q <= 1'b0;
      end
      if (rx_done_i) begin
        rx_q      <= rx_word_i;
        rx_full_q <= 1'b1;
      end else if (rd_en_i) begin
        rx_full_q <= 1'b0;
      end
      if (under_i)      under_q <= 1'b1;
      else if (wr_en_i) under_q <= 1'b0;
    end
  end

  assign tx_valid_o = tx_valid_q;
  assign tx_word_o  = tx_q;
  assign rd_data_o  = rx_q;
  assign rx_full_o  = rx_full_q;
  assign underrun_o = under_q;

  // R7: receive flag rises only on a completed word
  a_r7_full_on_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rx_full_q) |-> $past(rx_done_i));

  // R8: receive flag only drops after a read
  a_r8_clear_by_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rx_full_q) |-> $past(rd_en_i));

  // R9: underrun only when nothing was pending
  a_r9_under_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(under_q) |-> !$past(tx_valid_q));
endmodule

// File: rtl/spi_frm_slave.sv
module spi_frm_slave
  import spi_frm_pkg::*;
#(
  parameter int unsigned WORD_W      = SPI_WORD_W,
  parameter int unsigned SYNC_STAGES = SPI_SYNC_STAGES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              master_en_i,
  input  logic              frame_en_i,
  input  logic              sync_dir_i,
  input  logic              wr_en_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  output logic [WORD_W-1:0] rd_data_o,
  output logic              rx_full_o,
  output logic              underrun_o,
  input  logic              sck_i,
  input  logic              sdi_i,
  output logic              sdo_o,
  input  logic              ss_i,
  output logic              ss_o,
  output logic              ss_oe_o
);
  localparam int unsigned PINS = 3;

  logic [PINS-1:0]   pins_s;
  logic              sck_s, sdi_s, ss_s, sck_q, rise, fall, active;
  logic              take, under, rx_done, tx_valid;
  logic [WORD_W-1:0] rx_word, tx_word;

  spi_frm_sync #(.WIDTH(PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sck_i, sdi_i, ss_i}),
    .q_o   (pins_s)
  );

  assign {sck_s, sdi_s, ss_s} = pins_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sck_q <= 1'b0;
    else         sck_q <= sck_s;
  end

  assign rise    = sck_s & ~sck_q;
  assign fall    = ~sck_s & sck_q;
  assign active  = !master_en_i && frame_en_i;
  assign ss_oe_o = active && !sync_dir_i;

  spi_frm_engine #(.WORD_W(WORD_W)) u_engine (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .active_i  (active),
    .sync_dir_i(sync_dir_i),
    .rise_i    (rise),
    .fall_i    (fall),
    .ss_s_i    (ss_s),
    .sdi_s_i   (sdi_s),
    .tx_valid_i(tx_valid),
    .tx_word_i (tx_word),
    .take_o    (take),
    .under_o   (under),
    .rx_done_o (rx_done),
    .rx_word_o (rx_word),
    .sdo_o     (sdo_o),
    .ss_o      (ss_o)
  );

  spi_frm_regs #(.WORD_W(WORD_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .rd_en_i   (rd_en_i),
    .take_i    (take),
    .under_i   (under),
    .rx_done_i (rx_done),
    .rx_word_i (rx_word),
    .tx_valid_o(tx_valid),
    .tx_word_o (tx_word),
    .rd_data_o (rd_data_o),
    .rx_full_o (rx_full_o),
    .underrun_o(underrun_o)
  );

  // R2: pulse only driven when the pin was owned
  a_r2_pulse_owned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ss_o) |-> $past(ss_oe_o));
endmodule

// File: tb/spi_frm_slave_test.sv
`timescale 1ns/1ps
module spi_frm_slave_test;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        master_en = 1'b0, frame_en = 1'b1, sync_dir = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic        rx_full, underrun;
  logic        sck = 1'b0, sdi = 1'b0, ss_in = 1'b0;
  logic        sdo, ss_out, ss_oe;

  int total = 0, bad = 0, settle = 0;
  bit mon_on = 1'b0;

  // behavioural reference model
  int          m_st = 0, m_cnt = 0;  // 0 idle, 1 pulse, 2 data
  logic [15:0] m_sh = '0, m_rx = '0, m_rxbuf = '0;
  logic        m_sdo = 0, m_ss = 0, m_pend = 0, m_rxfull = 0, m_under = 0;
  logic [15:0] m_txq[$];

  always #2 clk = ~clk;

  spi_frm_slave uut (
    .clk_i(clk), .rst_ni(rst_n), .master_en_i(master_en), .frame_en_i(frame_en),
    .sync_dir_i(sync_dir), .wr_en_i(wr_en), .wr_data_i(wr_data), .rd_en_i(rd_en),
    .rd_data_o(rd_data), .rx_full_o(rx_full), .underrun_o(underrun),
    .sck_i(sck), .sdi_i(sdi), .sdo_o(sdo), .ss_i(ss_in), .ss_o(ss_out), .ss_oe_o(ss_oe)
  );

  function automatic bit m_act();
    return !master_en && frame_en;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s at %0t: actual=%0h expected=%0h", req, $time, act, exp);
    end
  endtask

  task automatic m_reset_engine();
    m_st = 0; m_cnt = 0; m_pend = 0; m_sdo = 0; m_ss = 0;
  endtask

  task automatic model_rise();
    if (!m_act()) return;
    if (sync_dir && ss_in) m_pend = 1;
    if (m_st == 2) begin
      m_rx = {m_rx[14:0], sdi};
      m_cnt++;
      if (m_cnt == 16) begin
        m_rxbuf = m_rx; m_rxfull = 1; m_st = 0;
      end
    end
  endtask

  task automatic model_fall();
    logic [15:0] w;
    if (!m_act()) return;
    if (sync_dir) begin
      if (m_pend) begin
        m_pend = 0;
        if (m_txq.size() > 0) w = m_txq.pop_front();
        else begin w = '0; m_under = 1; end
        m_st = 2; m_cnt = 0; m_sdo = w[15]; m_sh = w << 1;
      end else if (m_st == 2) begin
        m_sdo = m_sh[15]; m_sh = m_sh << 1;
      end else m_sdo = 0;
    end else begin
      if (m_st == 1) begin
        m_ss = 0; m_st = 2; m_cnt = 0; m_sdo = m_sh[15]; m_sh = m_sh << 1;
      end else if (m_st == 0 && m_txq.size() > 0) begin
        m_ss = 1; m_st = 1; m_sh = m_txq.pop_front(); m_sdo = 0;
      end else if (m_st == 2) begin
        m_sdo = m_sh[15]; m_sh = m_sh << 1;
      end else m_sdo = 0;
    end
  endtask

  // per-clock comparison once the synchronizer latency has passed
  always @(posedge clk) begin
    #1;
    if (settle < 1000) settle++;
    if (mon_on && settle >= 3) begin
      chk("R3/R4 ss_o", 32'(ss_out), 32'(m_ss));
      chk("R5/R12 sdo_o", 32'(sdo), 32'(m_sdo));
      chk("R2 ss_oe_o", 32'(ss_oe), 32'(m_act() && !sync_dir));
      chk("R7/R8 rx_full_o", 32'(rx_full), 32'(m_rxfull));
      chk("R9 underrun_o", 32'(underrun), 32'(m_under));
    end
  end

  task automatic sck_cycle(input logic nss, input logic nsdi);
    @(negedge clk); sck = 1'b1; settle = 0; model_rise();
    repeat (4) @(negedge clk);
    sck = 1'b0; ss_in = nss; sdi = nsdi; settle = 0; model_fall();
    repeat (3) @(negedge clk);
  endtask

  task automatic run(input int n, input bit rnd_ss);
    for (int i = 0; i < n; i++) sck_cycle(rnd_ss ? 1'($urandom) : 1'b0, 1'($urandom));
  endtask

  task automatic sync_pulse();
    sck_cycle(1'b1, 1'($urandom));
    sck_cycle(1'b0, 1'($urandom));
  endtask

  task automatic write_word(input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    m_txq.delete(); m_txq.push_back(d); m_under = 0;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic read_word(input string req);
    @(negedge clk);
    chk({req, " rx_full_o before read"}, 32'(rx_full), 32'(m_rxfull));
    chk({req, " rd_data_o"}, 32'(rd_data), 32'(m_rxbuf));
    rd_en = 1'b1; m_rxfull = 0;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic set_cfg(input logic me, input logic fe, input logic dir);
    @(negedge clk);
    master_en = me; frame_en = fe; sync_dir = dir; settle = 0;
    if (!m_act()) m_reset_engine();
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #600000;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // reset state
    chk("R1 reset sdo_o", 32'(sdo), 0);
    chk("R3 reset ss_o", 32'(ss_out), 0);
    chk("R7 reset rx_full_o", 32'(rx_full), 0);
    chk("R9 reset underrun_o", 32'(underrun), 0);
    chk("R2 reset ss_oe_o", 32'(ss_oe), 1);
    mon_on = 1'b1;

    // generating mode, idle clocks with noisy ss_i: no pulse (R2, R3)
    run(4, 1'b1);
    chk("R3 no pulse without word", 32'(ss_out), 0);

    // R3 R4 R5: single generated word
    write_word(16'hA5C3);
    run(20, 1'b1);
    read_word("R7 gen");

    // R11: queued word during a transfer, back to back
    write_word(16'h8001);
    run(5, 1'b0);
    write_word(16'h7FFE);
    run(40, 1'b0);
    read_word("R11 gen");

    // R6: following mode
    set_cfg(1'b0, 1'b1, 1'b1);
    chk("R2 follow ss_oe_o", 32'(ss_oe), 0);
    run(3, 1'b0);
    chk("R6 no start without sync", 32'(sdo), 0);
    write_word(16'h1234);
    sync_pulse();
    run(18, 1'b0);
    read_word("R6 follow");

    // R9: underrun, sticky, then cleared by write
    sync_pulse();
    run(18, 1'b0);
    chk("R9 underrun set", 32'(underrun), 1);
    read_word("R9 zeros");
    sync_pulse();
    run(18, 1'b0);
    chk("R9 underrun sticky", 32'(underrun), 1);
    write_word(16'hBEEF);
    repeat (4) @(negedge clk);
    chk("R9 cleared by write", 32'(underrun), 0);

    // R11: following-mode back to back (sync on 16th rise)
    sync_pulse();
    run(15, 1'b0);
    write_word(16'hC0DE);
    sck_cycle(1'b1, 1'($urandom));
    sck_cycle(1'b0, 1'($urandom));
    run(17, 1'b0);
    read_word("R11 follow");

    // R10: restart mid-word
    write_word(16'hF00F);
    sync_pulse();
    run(5, 1'b0);
    write_word(16'h0FF0);
    sync_pulse();
    run(18, 1'b0);
    read_word("R10 restart");

    // R8: read with nothing new leaves flag clear
    read_word("R8 empty read");

    // R1: inactive settings ignore pins
    set_cfg(1'b1, 1'b1, 1'b1);
    chk("R1 master_en ss_oe_o", 32'(ss_oe), 0);
    write_word(16'h5555);
    sync_pulse();
    run(18, 1'b1);
    chk("R1 no rx when off", 32'(rx_full), 0);
    set_cfg(1'b0, 1'b0, 1'b0);
    run(20, 1'b1);
    chk("R1 frame_en off sdo_o", 32'(sdo), 0);
    chk("R1 frame_en off ss_o", 32'(ss_out), 0);

    // back on in generating mode: held word goes out
    set_cfg(1'b0, 1'b1, 1'b0);
    run(20, 1'b0);
    read_word("R5 after enable");

    mon_on = 1'b0;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule